// File: doc/BRIEF.md
# Buffered Program Sequence Controller

This block sits behind a flash-style bus-write port and accepts a counted, multi-write request to program a burst of words into one page of one block. A setup write opens the request and picks the target block. A count write gives N, and the request then carries N+1 words. N+1 address/data writes fill a page-sized load buffer, and a final confirm write hands the whole buffer to a program engine. Every write is checked against the expected phase. Every load address must fall in the same page of the chosen block. Any fault ends the request with sticky error flags and no hand-off, so the array is never touched by a bad request.

From the setup write onward, reads are steered to the status byte. Bit 7 of that byte tells software when the engine is busy. The physical programming is replaced by a stub that reports completion a fixed number of cycles after it starts. Word mode (16-bit data, 16 slots) is the default. Setting a parameter selects byte mode, with 8-bit data and 32 slots.

Top module: `bufprog_ctrl`

## Requirements
- R1: After reset, status reads 80h, `ready` is 1, `rd_is_status` is 0 and `pgm_start` is 0.
- R2: In the idle phase, command E8h (data bits 7:0) opens a request and sets `rd_is_status`. Command 70h also sets `rd_is_status`, and FFh clears it. An aborted or completed request leaves `rd_is_status` at 1.
- R3: The count write carries N in data bits 7:0, and exactly N+1 load writes follow. N above the slot count minus one (15 in word mode) sets status bits 5 and 4 and ends the request.
- R4: A count write whose block field (address bits [ADDR_W-1 -: BLK_W]) differs from the setup write's block sets status bits 5 and 4 and ends the request.
- R5: A load write's low OFS_W address bits select its buffer slot. All load writes must share the page field (the address bits above the slot bits) with the first load and lie in the setup block. A load write that breaks either rule sets status bits 5 and 4 and ends the request without a hand-off.
- R6: A confirm write of D0h in an unprotected block pulses `pgm_start` for one cycle in the following cycle. With that pulse, `pgm_page` gives the page and `pgm_mask` has a 1 for each loaded slot. `pgm_data` slot i sits at bits [i*DATA_W +: DATA_W], and a slot that was not loaded reads all ones with mask 0.
- R7: A confirm write with data other than D0h sets status bits 5 and 4, and no pulse appears.
- R8: If `blk_prot` is 1 for the target block at the confirm write, status bits 4 and 1 are set and no pulse appears.
- R9: `ready` (status bit 7) is 0 from the cycle of the `pgm_start` pulse for ENG_LAT+1 cycles. Writes made in that window are ignored.
- R10: Error bits 5, 4 and 1 are sticky. While any of them is set, a setup write is refused. Command 50h in the idle phase clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address: block field on top, slot bits at the bottom |
| wr_data | input | DATA_W | Write data or command code in bits 7:0 |
| blk_prot | input | 2**BLK_W | Per-block protection flags |
| status | output | 8 | Status byte: bit 7 ready, bit 5 sequence error, bit 4 program error, bit 1 protection error |
| ready | output | 1 | Engine idle |
| rd_is_status | output | 1 | Reads return the status byte instead of the array |
| pgm_start | output | 1 | One-cycle hand-off pulse to the program engine |
| pgm_page | output | ADDR_W-OFS_W | Page address handed over |
| pgm_mask | output | SLOTS | Loaded-slot mask |
| pgm_data | output | SLOTS*DATA_W | Buffer contents, flattened by slot |

## Verification
A wrong phase or a wrong remaining-count register shows up at the ports within one write. The error bits rise one cycle after the offending write, or `pgm_start` appears or fails to appear one cycle after the write that should have confirmed. A stale or mis-indexed buffer slot is only visible in `pgm_mask` and `pgm_data` during the hand-off cycle, so the bench compares every slot in that cycle. A wrong busy counter is visible as a `ready` edge one or more cycles away from ENG_LAT+1.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COUNT,
      ST_LOAD,
      ST_CONFIRM,
      ST_BUSY
   } bp_state_e;

   localparam logic [7:0] CMD_OPEN   = 8'hE8;
   localparam logic [7:0] CMD_GO     = 8'hD0;
   localparam logic [7:0] CMD_CLEAR  = 8'h50;
   localparam logic [7:0] CMD_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_STATUS = 8'h70;
endpackage

// File: rtl/bp_load_buf.sv
module bp_load_buf #(
   parameter int SLOTS  = 16,
   parameter int DATA_W = 16,
   parameter int OFS_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    we,
   input  logic [OFS_W-1:0]        ofs,
   input  logic [DATA_W-1:0]       din,
   output logic [SLOTS-1:0]        mask_o,
   output logic [SLOTS*DATA_W-1:0] data_o
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            mask_o[i]                   <= 1'b0;
            data_o[i*DATA_W +: DATA_W]  <= '1;
         end else if (we && ofs == OFS_W'(i)) begin
            mask_o[i]                   <= 1'b1;
            data_o[i*DATA_W +: DATA_W]  <= din;
         end
      end
   end
endmodule

// File: rtl/bp_prog_stub.sv
module bp_prog_stub #(
   parameter int ENG_LAT = 6,
   localparam int CNT_W  = $clog2(ENG_LAT + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= CNT_W'(ENG_LAT);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/bp_seq_fsm.sv
module bp_seq_fsm
   import bp_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int BLK_W  = 3,
   parameter int OFS_W  = 4,
   localparam int NBLK  = 1 << BLK_W,
   localparam int MAX_N = (1 << OFS_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [7:0]        cmd,
   input  logic [NBLK-1:0]   blk_prot,
   input  logic              eng_done,
   output logic              buf_clr,
   output logic              buf_we,
   output logic              start,
   output logic              busy,
   output logic              rd_stat,
   output logic              err_seq,
   output logic              err_pgm,
   output logic              err_prot,
   output logic [PAGE_W-1:0] page_q
);
   bp_state_e         state_q;
   logic [BLK_W-1:0]  blk_q;
   logic [OFS_W-1:0]  rem_q;
   logic              pset_q;
   logic [BLK_W-1:0]  blk_in;
   logic              blk_ok, page_ok, n_ok, err_any;

   assign blk_in  = wr_page[PAGE_W-1 -: BLK_W];
   assign blk_ok  = (blk_in == blk_q);
   assign page_ok = !pset_q || (wr_page == page_q);
   assign n_ok    = (cmd <= 8'(MAX_N));
   assign err_any = err_seq | err_pgm | err_prot;
   assign busy    = (state_q == ST_BUSY);

   always_comb begin
      buf_clr = wr_en && state_q == ST_IDLE && cmd == CMD_OPEN && !err_any;
      buf_we  = wr_en && state_q == ST_LOAD && blk_ok && page_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         blk_q    <= '0;
         rem_q    <= '0;
         pset_q   <= 1'b0;
         page_q   <= '0;
         start    <= 1'b0;
         rd_stat  <= 1'b0;
         err_seq  <= 1'b0;
         err_pgm  <= 1'b0;
         err_prot <= 1'b0;
      end else begin
         start <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (wr_en) begin
               unique case (cmd)
                  CMD_ARRAY:  rd_stat <= 1'b0;
                  CMD_STATUS: rd_stat <= 1'b1;
                  CMD_CLEAR: begin
                     err_seq  <= 1'b0;
                     err_pgm  <= 1'b0;
                     err_prot <= 1'b0;
                  end
                  CMD_OPEN: begin
                     rd_stat <= 1'b1;
                     if (!err_any) begin
                        blk_q   <= blk_in;
                        state_q <= ST_COUNT;
                     end
                  end
                  default: ;
               endcase
            end
            ST_COUNT: if (wr_en) begin
               if (!blk_ok || !n_ok) begin
                  err_seq <= 1'b1;
                  err_pgm <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  rem_q   <= cmd[OFS_W-1:0];
                  pset_q  <= 1'b0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: if (wr_en) begin
               if (!blk_ok || !page_ok) begin
                  err_seq <= 1'b1;
                  err_pgm <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  page_q <= wr_page;
                  pset_q <= 1'b1;
                  if (rem_q == '0) state_q <= ST_CONFIRM;
                  else             rem_q   <= rem_q - 1'b1;
               end
            end
            ST_CONFIRM: if (wr_en) begin
               if (cmd != CMD_GO) begin
                  err_seq <= 1'b1;
                  err_pgm <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (blk_prot[blk_q]) begin
                  err_prot <= 1'b1;
                  err_pgm  <= 1'b1;
                  state_q  <= ST_IDLE;
               end else begin
                  start   <= 1'b1;
                  state_q <= ST_BUSY;
               end
            end
            ST_BUSY: if (eng_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bufprog_ctrl.sv
module bufprog_ctrl #(
   parameter int  ADDR_W    = 12,
   parameter int  BLK_W     = 3,
   parameter int  BYTE_MODE = 0,
   parameter int  ENG_LAT   = 6,
   localparam int SLOTS     = (BYTE_MODE != 0) ? 32 : 16,
   localparam int OFS_W     = (BYTE_MODE != 0) ? 5 : 4,
   localparam int DATA_W    = (BYTE_MODE != 0) ? 8 : 16,
   localparam int NBLK      = 1 << BLK_W,
   localparam int PAGE_W    = ADDR_W - OFS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [NBLK-1:0]         blk_prot,
   output logic [7:0]              status,
   output logic                    ready,
   output logic                    rd_is_status,
   output logic                    pgm_start,
   output logic [PAGE_W-1:0]       pgm_page,
   output logic [SLOTS-1:0]        pgm_mask,
   output logic [SLOTS*DATA_W-1:0] pgm_data
);
   if (BYTE_MODE != 0 && BYTE_MODE != 1) begin : g_bad_mode
      $error("BYTE_MODE must be 0 or 1");
   end
   if (BLK_W < 1 || BLK_W > PAGE_W) begin : g_bad_blk
      $error("BLK_W must lie in 1..ADDR_W-OFS_W");
   end
   if (ENG_LAT < 1) begin : g_bad_lat
      $error("ENG_LAT must be at least 1");
   end

   logic buf_clr, buf_we, eng_done, busy;
   logic err_seq, err_pgm, err_prot;

   bp_seq_fsm #(
      .PAGE_W (PAGE_W),
      .BLK_W  (BLK_W),
      .OFS_W  (OFS_W)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_page  (wr_addr[ADDR_W-1:OFS_W]),
      .cmd      (wr_data[7:0]),
      .blk_prot (blk_prot),
      .eng_done (eng_done),
      .buf_clr  (buf_clr),
      .buf_we   (buf_we),
      .start    (pgm_start),
      .busy     (busy),
      .rd_stat  (rd_is_status),
      .err_seq  (err_seq),
      .err_pgm  (err_pgm),
      .err_prot (err_prot),
      .page_q   (pgm_page)
   );

   bp_load_buf #(
      .SLOTS  (SLOTS),
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W)
   ) i_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (buf_clr),
      .we     (buf_we),
      .ofs    (wr_addr[OFS_W-1:0]),
      .din    (wr_data),
      .mask_o (pgm_mask),
      .data_o (pgm_data)
   );

   bp_prog_stub #(
      .ENG_LAT (ENG_LAT)
   ) i_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .start (pgm_start),
      .done  (eng_done)
   );

   assign ready  = !busy;
   assign status = {ready, 1'b0, err_seq, err_pgm, 2'b00, err_prot, 1'b0};
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
   parameter int SLOTS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       cmd,
   input logic             st_seq,
   input logic             st_pgm,
   input logic             st_prot,
   input logic             ready,
   input logic             rd_is_status,
   input logic             pgm_start,
   input logic [SLOTS-1:0] pgm_mask
);
   // R9
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> !ready);
   // R9
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> pgm_start);
   // R6
   start_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> (pgm_mask != '0));
   // R2
   start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> rd_is_status);
   // R7
   start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> (!st_seq && !st_pgm && !st_prot));
   // R10
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pgm && !(wr_en && cmd == 8'h50)) |=> st_pgm);
endmodule

bind bufprog_ctrl bp_chk #(.SLOTS(SLOTS)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .cmd          (wr_data[7:0]),
   .st_seq       (status[5]),
   .st_pgm       (status[4]),
   .st_prot      (status[1]),
   .ready        (ready),
   .rd_is_status (rd_is_status),
   .pgm_start    (pgm_start),
   .pgm_mask     (pgm_mask)
);

// File: tb/test_bufprog_ctrl.sv
module test_bufprog_ctrl;
   localparam int ADDR_W  = 12;
   localparam int BLK_W   = 3;
   localparam int ENG_LAT = 6;
   localparam int SLOTS   = 16;
   localparam int DW      = 16;
   localparam int OFS_W   = 4;
   localparam int BLK_SH  = ADDR_W - BLK_W;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst_n = 1'b0;
   logic                 wr_en = 1'b0;
   logic [ADDR_W-1:0]    wr_addr = '0;
   logic [DW-1:0]        wr_data = '0;
   logic [7:0]           blk_prot = '0;
   logic [7:0]           status;
   logic                 ready, rd_is_status, pgm_start;
   logic [ADDR_W-OFS_W-1:0] pgm_page;
   logic [SLOTS-1:0]     pgm_mask;
   logic [SLOTS*DW-1:0]  pgm_data;

   bufprog_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BYTE_MODE(0), .ENG_LAT(ENG_LAT)) i_bufprog_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .blk_prot(blk_prot), .status(status), .ready(ready), .rd_is_status(rd_is_status),
      .pgm_start(pgm_start), .pgm_page(pgm_page), .pgm_mask(pgm_mask), .pgm_data(pgm_data));

   int n_chk = 0, n_fail = 0, n_starts = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int       m_st, m_blk, m_page, m_rem, m_busy;
   bit       m_pset, m_e5, m_e4, m_e1, m_rds, m_start;
   bit       m_mask [SLOTS];
   int       m_data [SLOTS];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_blk = 0; m_page = 0; m_rem = 0; m_busy = 0;
         m_pset = 0; m_e5 = 0; m_e4 = 0; m_e1 = 0; m_rds = 0; m_start = 0;
         for (int i = 0; i < SLOTS; i++) begin m_mask[i] = 0; m_data[i] = 'hFFFF; end
      end else begin
         int cmd, blk, pg, ofs;
         cmd = int'(wr_data[7:0]);
         blk = int'(wr_addr) >> BLK_SH;
         pg  = int'(wr_addr) >> OFS_W;
         ofs = int'(wr_addr) % SLOTS;
         m_start = 0;
         if (m_busy > 0) m_busy--;
         else if (wr_en) begin
            case (m_st)
               0: begin
                  if (cmd == 'hFF) m_rds = 0;
                  else if (cmd == 'h70) m_rds = 1;
                  else if (cmd == 'h50) begin m_e5 = 0; m_e4 = 0; m_e1 = 0; end
                  else if (cmd == 'hE8) begin
                     m_rds = 1;
                     if (!(m_e5 || m_e4 || m_e1)) begin
                        m_blk = blk; m_st = 1;
                        for (int i = 0; i < SLOTS; i++) begin m_mask[i] = 0; m_data[i] = 'hFFFF; end
                     end
                  end
               end
               1: if (blk != m_blk || cmd > SLOTS - 1) begin m_e5 = 1; m_e4 = 1; m_st = 0; end
                  else begin m_rem = cmd; m_pset = 0; m_st = 2; end
               2: if (blk != m_blk || (m_pset && pg != m_page)) begin m_e5 = 1; m_e4 = 1; m_st = 0; end
                  else begin
                     m_mask[ofs] = 1; m_data[ofs] = int'(wr_data);
                     m_page = pg; m_pset = 1;
                     if (m_rem == 0) m_st = 3; else m_rem--;
                  end
               default: begin
                  if (cmd != 'hD0) begin m_e5 = 1; m_e4 = 1; end
                  else if (blk_prot[m_blk]) begin m_e1 = 1; m_e4 = 1; end
                  else begin m_start = 1; m_busy = ENG_LAT + 1; end
                  m_st = 0;
               end
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [7:0] exp_st;
         exp_st = {m_busy == 0, 1'b0, m_e5, m_e4, 2'b00, m_e1, 1'b0};
         chk("R10 status byte", status, exp_st);
         chk("R9 ready", ready, m_busy == 0);
         chk("R2 read source", rd_is_status, m_rds);
         chk("R6 start pulse", pgm_start, m_start);
         if (m_start && pgm_start) begin
            chk("R6 page", pgm_page, m_page);
            for (int i = 0; i < SLOTS; i++) begin
               chk("R6 slot mask", pgm_mask[i], m_mask[i]);
               chk("R6 slot data", pgm_data[i*DW +: DW], m_data[i]);
            end
         end
         if (pgm_start) n_starts++;
      end
   end

   function automatic logic [ADDR_W-1:0] mk(input int blk, input int pg, input int ofs);
      return {blk[2:0], pg[4:0], ofs[3:0]};
   endfunction

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // full good request: loads n+1 words at slots (i*stride)%16
   task automatic good_req(input int blk, input int pg, input int n, input int stride);
      wr(mk(blk, pg, 0), 16'h00E8);
      wr(mk(blk, pg, 0), 16'(n));
      for (int i = 0; i <= n; i++) wr(mk(blk, pg, (i * stride) % SLOTS), 16'(16'h1200 + blk * 16 + i));
      wr(mk(blk, pg, 0), 16'h00D0);
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int s0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset status", status, 8'h80);
      chk("R1 reset ready", ready, 1);
      chk("R1 reset read source", rd_is_status, 0);
      chk("R1 reset start", pgm_start, 0);

      wr(mk(0, 0, 0), 16'h0070);
      chk("R2 status read cmd", rd_is_status, 1);
      wr(mk(0, 0, 0), 16'h00FF);
      chk("R2 array read cmd", rd_is_status, 0);

      // R6: four scattered words in block 2 page 3
      wr(mk(2, 3, 0), 16'h00E8);
      chk("R2 setup selects status", rd_is_status, 1);
      wr(mk(2, 3, 0), 16'd3);
      wr(mk(2, 3, 2), 16'hA002);
      wr(mk(2, 3, 5), 16'hA005);
      wr(mk(2, 3, 0), 16'hA000);
      wr(mk(2, 3, 15), 16'hA00F);
      wr(mk(2, 3, 0), 16'h00D0);
      chk("R6 hand-off pulse", pgm_start, 1);
      chk("R6 loaded mask", pgm_mask, 16'h8025);
      chk("R6 unloaded slot erased", pgm_data[1*DW +: DW], 16'hFFFF);
      chk("R6 slot 5 data", pgm_data[5*DW +: DW], 16'hA005);
      chk("R9 busy after confirm", status, 8'h00);
      wr(mk(2, 3, 0), 16'h00FF);
      chk("R9 write in busy ignored", rd_is_status, 1);
      idle(ENG_LAT + 1);
      chk("R9 ready back", ready, 1);

      good_req(0, 1, 0, 1);
      idle(ENG_LAT + 2);
      good_req(7, 31, 15, 1);
      chk("R6 full mask", pgm_mask, 16'hFFFF);
      idle(ENG_LAT + 2);
      good_req(5, 9, 6, 3);
      idle(ENG_LAT + 2);
      chk("R6 three good hand-offs plus first", n_starts, 4);

      // R3: count too large
      s0 = n_starts;
      wr(mk(1, 2, 0), 16'h00E8);
      wr(mk(1, 2, 0), 16'd16);
      chk("R3 count over range", status, 8'hB0);
      // R10: setup refused while error pending
      wr(mk(1, 2, 0), 16'h00E8);
      wr(mk(1, 2, 0), 16'd0);
      wr(mk(1, 2, 4), 16'h1234);
      wr(mk(1, 2, 0), 16'h00D0);
      idle(2);
      chk("R10 refused setup no start", n_starts, s0);
      chk("R10 error sticky", status, 8'hB0);
      wr(mk(1, 2, 0), 16'h0050);
      chk("R10 clear", status, 8'h80);

      // R4: count in another block
      wr(mk(1, 2, 0), 16'h00E8);
      wr(mk(2, 2, 0), 16'd1);
      chk("R4 count block mismatch", status, 8'hB0);
      wr(mk(0, 0, 0), 16'h0050);

      // R5: page change mid-load
      wr(mk(1, 2, 0), 16'h00E8);
      wr(mk(1, 2, 0), 16'd2);
      wr(mk(1, 2, 1), 16'h1111);
      wr(mk(1, 3, 2), 16'h2222);
      chk("R5 page mismatch", status, 8'hB0);
      wr(mk(1, 2, 0), 16'h0050);
      // R5: load outside block
      wr(mk(3, 0, 0), 16'h00E8);
      wr(mk(3, 0, 0), 16'd1);
      wr(mk(4, 0, 1), 16'h3333);
      chk("R5 block mismatch on load", status, 8'hB0);
      wr(mk(3, 0, 0), 16'h0050);

      // R7: wrong confirm code
      wr(mk(6, 4, 0), 16'h00E8);
      wr(mk(6, 4, 0), 16'd0);
      wr(mk(6, 4, 7), 16'h4444);
      wr(mk(6, 4, 0), 16'h00D1);
      chk("R7 bad confirm", status, 8'hB0);
      wr(mk(6, 4, 0), 16'h0050);

      // R8: protected block
      blk_prot = 8'h10;
      wr(mk(4, 1, 0), 16'h00E8);
      wr(mk(4, 1, 0), 16'd1);
      wr(mk(4, 1, 3), 16'h5555);
      wr(mk(4, 1, 4), 16'h6666);
      wr(mk(4, 1, 0), 16'h00D0);
      chk("R8 protected abort", status, 8'h92);
      chk("R2 read source after abort", rd_is_status, 1);
      wr(mk(4, 1, 0), 16'h0050);
      chk("R10 clear protect flag", status, 8'h80);
      idle(2);
      chk("R7 R8 no hand-off on errors", n_starts, s0);
      blk_prot = 8'h00;

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule